// File: doc/BRIEF.md
# Four-Bank SDRAM Command Spacing Checker

This block sits beside a memory controller, or on a monitor tap of the command bus, and judges every decoded command sent to a four-bank SDRAM. Each command comes with its bank number. The block tracks which banks hold an open row. It also measures, in clock cycles, the time since the relevant earlier events. For each command it reports whether that command respects the protocol and the minimum and maximum spacings. When a command breaks more than one rule, it reports the most important one.

Every spacing is a parameter in clock cycles. The write-data end point is derived from the write latency and the burst length. A command that is judged illegal is reported and then discarded. The tracked state follows only the commands that were accepted, so one mistake does not cause a cascade of false reports. The verdict for a command appears exactly one cycle after it, on registered outputs.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset, chk_valid, chk_ok and chk_code are all 0. All banks are idle, and no earlier event restricts the first commands.
- R2: A command presented with cmd_valid high is reported with chk_valid high on the next cycle. chk_ok is 1 with chk_code 0 when the command is legal. chk_valid is low on the cycle after a cycle without a command.
- R3: cmd_op encodes 0 activate, 1 read, 2 write, 3 precharge one bank, 4 precharge all, 5 auto-refresh and 6 mode-register write. Code 7 is reserved and is reported with chk_code 1.
- R4: The following are reported with chk_code 2: an activate to an open bank, a read or write to an idle bank, and an auto-refresh or mode-register write while any bank is open.
- R5: An activate closer than T_RRD to the last accepted activate of any bank gives code 5. One closer than T_RC to the same bank's last activate gives code 6. One closer than T_RP to that bank's last precharge gives code 7.
- R6: A read closer than T_RCDRD to its bank's activate gives code 8. A write closer than T_RCDWR gives code 9, and T_RCDRD is larger than T_RCDWR.
- R7: A read is legal only when at least WL + BL/2 + T_CDLR cycles have passed since the last accepted write of any bank. Otherwise it gives code 10.
- R8: A precharge of an open bank gives code 11 if fewer than T_RAS cycles have passed since its activate. It gives code 12 if more than T_RAS_MAX cycles have passed. It gives code 13 if fewer than WL + BL/2 + T_WR cycles have passed since that bank's last write. Precharge-all applies these rules to every open bank. Precharging an idle bank is legal.
- R9: An auto-refresh or mode-register write needs every bank precharged for at least T_RP cycles, and otherwise gives code 7. Any command closer than T_RFC to an accepted auto-refresh gives code 3.
- R10: Any command closer than T_MRD to an accepted mode-register write gives code 4.
- R11: Reads and writes to an open, timed-out bank are legal on every consecutive cycle.
- R12: A command reported illegal changes no tracked state or timestamp.
- R13: When several rules are broken at once, the smallest chk_code number is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command encoding (R3) |
| cmd_bank | input | BW | Target bank |
| chk_valid | output | 1 | Verdict present for the previous cycle's command |
| chk_ok | output | 1 | Previous command was legal |
| chk_code | output | 4 | Violation code, 0 when legal |

## Verification
Several rules can be broken by the same command. The bench provokes this directly. A read is placed one cycle after a write and four cycles after its bank's activate, so it is both too early for the row-to-column delay and too close to the write data. The expected code is the read-delay code 8, not the write-to-read code 10. The bench then moves the same read to a later cycle, where only the write-to-read rule is broken, and checks that code 10 appears. This shows that the priority encoder masks a lower-ranked rule without losing it. The same approach is used for activates that break both the same-bank cycle rule and the precharge rule.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  localparam logic [2:0] OP_ACT  = 3'd0;
  localparam logic [2:0] OP_RD   = 3'd1;
  localparam logic [2:0] OP_WR   = 3'd2;
  localparam logic [2:0] OP_PRE  = 3'd3;
  localparam logic [2:0] OP_PREA = 3'd4;
  localparam logic [2:0] OP_REF  = 3'd5;
  localparam logic [2:0] OP_MRS  = 3'd6;

  // Violation codes; a smaller number wins when several apply.
  localparam int ERR_BAD_OP  = 1;
  localparam int ERR_STATE   = 2;
  localparam int ERR_RFC     = 3;
  localparam int ERR_MRD     = 4;
  localparam int ERR_RRD     = 5;
  localparam int ERR_RC      = 6;
  localparam int ERR_RP      = 7;
  localparam int ERR_RCDRD   = 8;
  localparam int ERR_RCDWR   = 9;
  localparam int ERR_CDLR    = 10;
  localparam int ERR_RAS_MIN = 11;
  localparam int ERR_RAS_MAX = 12;
  localparam int ERR_WREC    = 13;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_chk_since.sv
// Saturating "cycles since event" counter. The value seen on the cycle of a
// later command equals the distance in cycles to the restarting event.
module sdram_chk_since #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '1;
    else if (restart)       cnt <= CW'(1);
    else if (cnt != '1)     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sdram_chk_bank.sv
// Open/idle state of one bank plus its activate, precharge and write ages.
module sdram_chk_bank #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_act,
  input  logic          do_pre,
  input  logic          do_wr,
  output logic          is_open,
  output logic [CW-1:0] act_age,
  output logic [CW-1:0] pre_age,
  output logic [CW-1:0] wr_age
);
  always_ff @(posedge clk) begin
    if (rst)         is_open <= 1'b0;
    else if (do_act) is_open <= 1'b1;
    else if (do_pre) is_open <= 1'b0;
  end

  sdram_chk_since #(.CW(CW)) u_act (.clk(clk), .rst(rst), .restart(do_act), .cnt(act_age));
  sdram_chk_since #(.CW(CW)) u_pre (.clk(clk), .rst(rst), .restart(do_pre), .cnt(pre_age));
  sdram_chk_since #(.CW(CW)) u_wr  (.clk(clk), .rst(rst), .restart(do_wr),  .cnt(wr_age));
endmodule

// File: rtl/sdram_chk_rules.sv
// Combinational judgement of the current command against tracked state.
module sdram_chk_rules
  import sdram_chk_pkg::*;
#(
  parameter int NB        = 4,
  parameter int BW        = 2,
  parameter int CW        = 17,
  parameter int T_RCDRD   = 5,
  parameter int T_RCDWR   = 3,
  parameter int T_RAS     = 10,
  parameter int T_RAS_MAX = 100000,
  parameter int T_RC      = 15,
  parameter int T_RRD     = 3,
  parameter int T_RP      = 5,
  parameter int T_RFC     = 17,
  parameter int T_WR      = 3,
  parameter int T_CDLR    = 3,
  parameter int T_MRD     = 2,
  parameter int WL        = 1,
  parameter int BL        = 4
) (
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [BW-1:0]          cmd_bank,
  input  logic [NB-1:0]          bank_open,
  input  logic [NB-1:0][CW-1:0]  act_age,
  input  logic [NB-1:0][CW-1:0]  pre_age,
  input  logic [NB-1:0][CW-1:0]  wr_age,
  input  logic [CW-1:0]          any_act_age,
  input  logic [CW-1:0]          any_wr_age,
  input  logic [CW-1:0]          ref_age,
  input  logic [CW-1:0]          mrs_age,
  output logic                   legal,
  output logic [3:0]             code,
  output logic [NB-1:0]          upd_act,
  output logic [NB-1:0]          upd_pre,
  output logic [NB-1:0]          upd_wr,
  output logic                   upd_any_act,
  output logic                   upd_any_wr,
  output logic                   upd_ref,
  output logic                   upd_mrs
);
  localparam int WDATA = WL + BL / 2;
  localparam logic [CW-1:0] L_RCDRD  = CW'(T_RCDRD);
  localparam logic [CW-1:0] L_RCDWR  = CW'(T_RCDWR);
  localparam logic [CW-1:0] L_RAS    = CW'(T_RAS);
  localparam logic [CW-1:0] L_RASMAX = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] L_RC     = CW'(T_RC);
  localparam logic [CW-1:0] L_RRD    = CW'(T_RRD);
  localparam logic [CW-1:0] L_RP     = CW'(T_RP);
  localparam logic [CW-1:0] L_RFC    = CW'(T_RFC);
  localparam logic [CW-1:0] L_WREC   = CW'(WDATA + T_WR);
  localparam logic [CW-1:0] L_CDLR   = CW'(WDATA + T_CDLR);
  localparam logic [CW-1:0] L_MRD    = CW'(T_MRD);

  logic          sel_open;
  logic [CW-1:0] sel_act, sel_pre, sel_wr;
  logic          all_ras_min, all_ras_max, all_wrec, all_rp, any_open;
  logic [15:0]   viol;

  assign sel_open = bank_open[cmd_bank];
  assign sel_act  = act_age[cmd_bank];
  assign sel_pre  = pre_age[cmd_bank];
  assign sel_wr   = wr_age[cmd_bank];
  assign any_open = |bank_open;

  // Rules that span every bank (precharge-all, refresh, mode write).
  always_comb begin
    all_ras_min = 1'b0;
    all_ras_max = 1'b0;
    all_wrec    = 1'b0;
    all_rp      = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (bank_open[b]) begin
        if (act_age[b] < L_RAS)    all_ras_min = 1'b1;
        if (act_age[b] > L_RASMAX) all_ras_max = 1'b1;
        if (wr_age[b] < L_WREC)    all_wrec    = 1'b1;
      end
      if (pre_age[b] < L_RP) all_rp = 1'b1;
    end
  end

  always_comb begin
    viol = '0;
    viol[ERR_RFC] = (ref_age < L_RFC);
    viol[ERR_MRD] = (mrs_age < L_MRD);
    case (cmd_op)
      OP_ACT: begin
        viol[ERR_STATE] = sel_open;
        viol[ERR_RRD]   = (any_act_age < L_RRD);
        viol[ERR_RC]    = (sel_act < L_RC);
        viol[ERR_RP]    = (sel_pre < L_RP);
      end
      OP_RD: begin
        viol[ERR_STATE] = !sel_open;
        viol[ERR_RCDRD] = (sel_act < L_RCDRD);
        viol[ERR_CDLR]  = (any_wr_age < L_CDLR);
      end
      OP_WR: begin
        viol[ERR_STATE] = !sel_open;
        viol[ERR_RCDWR] = (sel_act < L_RCDWR);
      end
      OP_PRE: begin
        viol[ERR_RAS_MIN] = sel_open && (sel_act < L_RAS);
        viol[ERR_RAS_MAX] = sel_open && (sel_act > L_RASMAX);
        viol[ERR_WREC]    = sel_open && (sel_wr < L_WREC);
      end
      OP_PREA: begin
        viol[ERR_RAS_MIN] = all_ras_min;
        viol[ERR_RAS_MAX] = all_ras_max;
        viol[ERR_WREC]    = all_wrec;
      end
      OP_REF, OP_MRS: begin
        viol[ERR_STATE] = any_open;
        viol[ERR_RP]    = all_rp;
      end
      default: viol[ERR_BAD_OP] = 1'b1;
    endcase
  end

  // Lowest-numbered violation wins.
  always_comb begin
    code = 4'd0;
    for (int i = 15; i >= 0; i--) begin
      if (viol[i]) code = 4'(i);
    end
  end

  assign legal = cmd_valid && (code == 4'd0);

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      upd_act[b] = legal && (cmd_op == OP_ACT) && (cmd_bank == BW'(b));
      upd_wr[b]  = legal && (cmd_op == OP_WR)  && (cmd_bank == BW'(b));
      upd_pre[b] = legal && (((cmd_op == OP_PRE) && (cmd_bank == BW'(b)))
                             || (cmd_op == OP_PREA));
    end
  end

  assign upd_any_act = legal && (cmd_op == OP_ACT);
  assign upd_any_wr  = legal && (cmd_op == OP_WR);
  assign upd_ref     = legal && (cmd_op == OP_REF);
  assign upd_mrs     = legal && (cmd_op == OP_MRS);
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NB        = 4,
  parameter int T_RCDRD   = 5,
  parameter int T_RCDWR   = 3,
  parameter int T_RAS     = 10,
  parameter int T_RAS_MAX = 100000,
  parameter int T_RC      = 15,
  parameter int T_RRD     = 3,
  parameter int T_RP      = 5,
  parameter int T_RFC     = 17,
  parameter int T_WR      = 3,
  parameter int T_CDLR    = 3,
  parameter int T_MRD     = 2,
  parameter int WL        = 1,
  parameter int BL        = 4,
  localparam int BW       = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  output logic          chk_valid,
  output logic          chk_ok,
  output logic [3:0]    chk_code
);
  localparam int TMAX = imax(imax(imax(T_RAS_MAX, T_RC), imax(T_RFC, T_RP)),
                             imax(WL + BL / 2 + imax(T_WR, T_CDLR),
                                  imax(T_RCDRD, imax(T_RRD, T_MRD))));
  localparam int CW = $clog2(TMAX + 2);

  logic [NB-1:0]         bank_open, upd_act, upd_pre, upd_wr;
  logic [NB-1:0][CW-1:0] act_age, pre_age, wr_age;
  logic [CW-1:0]         any_act_age, any_wr_age, ref_age, mrs_age;
  logic                  upd_any_act, upd_any_wr, upd_ref, upd_mrs;
  logic                  legal;
  logic [3:0]            code;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdram_chk_bank #(.CW(CW)) u_bank (
      .clk(clk), .rst(rst),
      .do_act(upd_act[b]), .do_pre(upd_pre[b]), .do_wr(upd_wr[b]),
      .is_open(bank_open[b]),
      .act_age(act_age[b]), .pre_age(pre_age[b]), .wr_age(wr_age[b])
    );
  end

  sdram_chk_since #(.CW(CW)) u_any_act (.clk(clk), .rst(rst), .restart(upd_any_act), .cnt(any_act_age));
  sdram_chk_since #(.CW(CW)) u_any_wr  (.clk(clk), .rst(rst), .restart(upd_any_wr),  .cnt(any_wr_age));
  sdram_chk_since #(.CW(CW)) u_ref     (.clk(clk), .rst(rst), .restart(upd_ref),     .cnt(ref_age));
  sdram_chk_since #(.CW(CW)) u_mrs     (.clk(clk), .rst(rst), .restart(upd_mrs),     .cnt(mrs_age));

  sdram_chk_rules #(
    .NB(NB), .BW(BW), .CW(CW),
    .T_RCDRD(T_RCDRD), .T_RCDWR(T_RCDWR), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX),
    .T_RC(T_RC), .T_RRD(T_RRD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR),
    .T_CDLR(T_CDLR), .T_MRD(T_MRD), .WL(WL), .BL(BL)
  ) u_rules (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .bank_open(bank_open), .act_age(act_age), .pre_age(pre_age), .wr_age(wr_age),
    .any_act_age(any_act_age), .any_wr_age(any_wr_age),
    .ref_age(ref_age), .mrs_age(mrs_age),
    .legal(legal), .code(code),
    .upd_act(upd_act), .upd_pre(upd_pre), .upd_wr(upd_wr),
    .upd_any_act(upd_any_act), .upd_any_wr(upd_any_wr),
    .upd_ref(upd_ref), .upd_mrs(upd_mrs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid <= 1'b0;
      chk_ok    <= 1'b0;
      chk_code  <= 4'd0;
    end else begin
      chk_valid <= cmd_valid;
      chk_ok    <= legal;
      chk_code  <= cmd_valid ? code : 4'd0;
    end
  end
endmodule

// File: rtl/sdram_chk_props.sv
module sdram_chk_props
  import sdram_chk_pkg::*;
#(
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [BW-1:0] cmd_bank,
  input logic          chk_valid,
  input logic          chk_ok,
  input logic [3:0]    chk_code
);
  a_r2_verdict_follows: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> chk_valid);

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !chk_valid);

  a_r2_ok_clean: assert property (@(posedge clk) disable iff (rst)
    chk_ok |-> (chk_valid && chk_code == 4'd0));

  a_r3_reserved_op: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd7) |=> (!chk_ok && chk_code == 4'd1));

  a_r4_reopen_flagged: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACT && chk_valid && chk_ok &&
     $past(cmd_op) == OP_ACT && $past(cmd_bank) == cmd_bank)
    |=> (chk_valid && !chk_ok));

  a_r9_refresh_guard: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && chk_valid && chk_ok && $past(cmd_op) == OP_REF)
    |=> (chk_valid && !chk_ok));

  a_r10_mode_guard: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && chk_valid && chk_ok && $past(cmd_op) == OP_MRS)
    |=> (chk_valid && !chk_ok));
endmodule

bind sdram_cmd_checker sdram_chk_props #(.BW(BW)) u_props (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .chk_valid(chk_valid), .chk_ok(chk_ok),
  .chk_code(chk_code)
);

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       chk_valid, chk_ok;
  logic [3:0] chk_code;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_cmd_checker #(.T_RAS_MAX(40)) u_sdram_cmd_checker (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .chk_valid(chk_valid), .chk_ok(chk_ok),
    .chk_code(chk_code)
  );

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One command per cycle; verdict sampled at the following falling edge.
  task automatic issue(input logic [2:0] op, input logic [1:0] bank,
                       input int exp_code, input string req);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank;
    @(negedge clk);
    n_chk++;
    if (!chk_valid || chk_ok != (exp_code == 0) || chk_code != 4'(exp_code)) begin
      n_bad++;
      $display("FAIL %s: op=%0d bank=%0d got valid=%0b ok=%0b code=%0d expected ok=%0b code=%0d",
               req, op, bank, chk_valid, chk_ok, chk_code, exp_code == 0, exp_code);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_chk++;
      if (chk_valid) begin
        n_bad++;
        $display("FAIL R2: chk_valid=%0b expected 0 on idle cycle", chk_valid);
      end
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    n_chk++;
    if (chk_valid || chk_ok || chk_code != 0) begin
      n_bad++;
      $display("FAIL R1: valid=%0b ok=%0b code=%0d expected 0 0 0", chk_valid, chk_ok, chk_code);
    end
  endtask

  task automatic t_bank_state();
    do_reset();
    issue(3'd1, 2'd0, 2, "R4 read idle bank");
    issue(3'd2, 2'd1, 2, "R4 write idle bank");
    issue(3'd3, 2'd1, 0, "R8 precharge idle bank");
    issue(3'd0, 2'd0, 0, "R1 first activate unrestricted");
    idle(20);
    issue(3'd0, 2'd0, 2, "R4 activate open bank");
    issue(3'd5, 2'd2, 2, "R4 refresh with open bank");
    issue(3'd6, 2'd2, 2, "R4 mode write with open bank");
    issue(3'd7, 2'd3, 1, "R3 reserved op");
  endtask

  task automatic t_row_to_col();
    do_reset();
    issue(3'd0, 2'd0, 0, "R6 activate");
    idle(3);
    issue(3'd1, 2'd0, 8, "R6 read at 4");
    issue(3'd1, 2'd0, 0, "R6 read at 5");
    do_reset();
    issue(3'd0, 2'd1, 0, "R6 activate");
    idle(1);
    issue(3'd2, 2'd1, 9, "R6 write at 2");
    issue(3'd2, 2'd1, 0, "R6 write at 3");
  endtask

  task automatic t_activate_spacing();
    do_reset();
    issue(3'd0, 2'd0, 0, "R5 act b0 t0");
    issue(3'd0, 2'd1, 5, "R5 rrd t1");
    idle(1);
    issue(3'd0, 2'd1, 0, "R12 act b1 t3 unaffected by rejected act");
    idle(5);
    issue(3'd3, 2'd0, 11, "R8 ras min t9");
    issue(3'd3, 2'd0, 0, "R8 precharge t10");
    idle(3);
    issue(3'd0, 2'd0, 6, "R13 rc over rp t14");
    issue(3'd0, 2'd0, 0, "R5 act b0 t15");
    issue(3'd3, 2'd1, 0, "R8 precharge b1 t16");
    idle(3);
    issue(3'd0, 2'd1, 7, "R5 rp t20");
    issue(3'd0, 2'd1, 0, "R5 act b1 t21");
  endtask

  task automatic t_write_rules();
    do_reset();
    issue(3'd0, 2'd0, 0, "R7 act t0");
    idle(2);
    issue(3'd2, 2'd0, 0, "R7 write t3");
    issue(3'd1, 2'd0, 8, "R13 read t4 rcd over cdlr");
    idle(3);
    issue(3'd1, 2'd0, 10, "R7 read t8 cdlr");
    issue(3'd1, 2'd0, 0, "R7 read t9");
    issue(3'd1, 2'd0, 0, "R11 read t10 back to back");
    issue(3'd2, 2'd0, 0, "R11 write t11");
    idle(4);
    issue(3'd3, 2'd0, 13, "R8 write recovery t16");
    issue(3'd3, 2'd0, 0, "R8 precharge t17");
  endtask

  task automatic t_mode_refresh();
    do_reset();
    issue(3'd0, 2'd2, 0, "R9 act t0");
    issue(3'd6, 2'd0, 2, "R4 mode write open t1");
    issue(3'd5, 2'd0, 2, "R4 refresh open t2");
    idle(7);
    issue(3'd4, 2'd0, 0, "R8 precharge all t10");
    issue(3'd6, 2'd0, 7, "R9 mode write rp t11");
    idle(3);
    issue(3'd6, 2'd0, 0, "R9 mode write t15");
    issue(3'd0, 2'd0, 4, "R10 mrd t16");
    issue(3'd5, 2'd0, 0, "R9 refresh t17");
    issue(3'd0, 2'd0, 3, "R9 rfc t18");
    idle(15);
    issue(3'd0, 2'd0, 0, "R9 act after rfc t34");
  endtask

  task automatic t_ras_max();
    do_reset();
    issue(3'd0, 2'd3, 0, "R8 act");
    idle(39);
    issue(3'd3, 2'd3, 0, "R8 precharge at max");
    do_reset();
    issue(3'd0, 2'd3, 0, "R8 act");
    idle(40);
    issue(3'd3, 2'd3, 12, "R8 precharge past max");
    issue(3'd4, 2'd0, 12, "R8 precharge all past max");
  endtask

  initial begin
    t_reset_state();
    t_bank_state();
    t_row_to_col();
    t_activate_spacing();
    t_write_rules();
    t_mode_refresh();
    t_ras_max();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule